// File: doc/BRIEF.md
# Ripple Amplitude Tracking Counter

This block adjusts the amplitude of a triangle-shaped cancellation current so that it follows the output ripple of a switching regulator. Once in each switching period an analog comparator reports a single bit: high when the sampled ripple peak still lies above the sampled valley, which means the ripple is not yet cancelled. Low means the cancellation amplitude has overshot. The block turns that stream of decisions into an unsigned amplitude code. A current-steering converter outside the block uses the code to set the charge and discharge current of the triangle generator.

The raw switching-node level enters asynchronously. It is synchronised, and each of its rising edges makes exactly one fast-clock update tick. On that tick the comparator bit moves a small signed pre-counter up or down. The amplitude code steps only when the pre-counter reaches its positive or negative limit, and the pre-counter then returns to zero. This filtering makes the code settle. Once cancellation is reached the comparator bit alternates from period to period, and the code then stays put instead of chattering. The code clamps at both ends of its range.

Top module: `rippleAmpTracker`

## Requirements
- R1: After reset the amplitude code equals the parameter INIT_CODE (default 0) and the pre-counter is centred at zero, so the first code step needs exactly PRE_LIMIT equal decisions.
- R2: Exactly one update happens per rising edge of swNode, on the clock edge SYNC_STAGES+1 edges after the rise. A steady high or low level of swNode causes no further update. Changes of peakAboveValley at any other clock have no effect on the code.
- R3: peakAboveValley = 1 at an update raises the pre-counter by one. When the pre-counter reaches +PRE_LIMIT, the code rises by one and the pre-counter returns to zero.
- R4: peakAboveValley = 0 at an update lowers the pre-counter by one. When the pre-counter reaches -PRE_LIMIT, the code falls by one and the pre-counter returns to zero.
- R5: With PRE_LIMIT of 2 or more, decisions that alternate from one update to the next leave the code constant.
- R6: At the all-ones value the code stays put on an upward step and never wraps to zero. The pre-counter is still re-centred.
- R7: At zero the code stays put on a downward step and never wraps to all ones. The pre-counter is still re-centred.
- R8: The code changes by at most one per clock, and only at an update tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swNode | input | 1 | Raw switching-node level, asynchronous |
| peakAboveValley | input | 1 | Comparator decision: 1 = peak above valley |
| ampCode | output | CODE_W | Amplitude code for the current-steering converter |

## Verification
The bench builds two copies with a 5-bit code, so that both clamps can be reached in a few dozen switching periods. One copy uses a pre-counter limit of 2 and a start code of 3. The other uses a limit of 3 and a start code of 28, so the two filtering depths are compared on the same stimulus. Runs of rising, alternating, falling and pseudo-random decisions drive both codes into each clamp and back, and every period is checked against an arithmetic model. The bench toggles the comparator bit on every clock other than the update clock, and holds swNode high for long stretches, to show that only the sampled bit counts.

// File: rtl/rat_pkg.sv
package rat_pkg;

  // Strobes from control to the code register.
  typedef struct packed {
    logic tick;      // one-clock update pulse per switching period
    logic stepUp;    // raise the code by one
    logic stepDown;  // lower the code by one
  } ampStep_t;

endpackage

// File: rtl/ampTrackCtrl.sv
module ampTrackCtrl
  import rat_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int PRE_LIMIT   = 2,  // 1 .. 2**(PRE_W-1)-1
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     swNode,
  input  logic     ctrlIn,
  output ampStep_t stepOut
);

  localparam logic signed [PRE_W-1:0] POS_LIM = PRE_W'(PRE_LIMIT);
  localparam logic signed [PRE_W-1:0] NEG_LIM = -POS_LIM;
  localparam logic signed [PRE_W-1:0] ONE     = PRE_W'(1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastQ;
  logic                   tick;
  logic signed [PRE_W-1:0] preQ;
  logic signed [PRE_W-1:0] preNext;
  logic                   hitPos;
  logic                   hitNeg;

  // Synchroniser chain for the switching node
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= swNode;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncQ[SYNC_STAGES-1];
  end

  assign tick = syncQ[SYNC_STAGES-1] & ~lastQ;

  // Filtering pre-counter
  always_comb begin
    if (ctrlIn) preNext = preQ + ONE;
    else        preNext = preQ - ONE;
  end

  assign hitPos = tick &  ctrlIn & (preNext == POS_LIM);
  assign hitNeg = tick & ~ctrlIn & (preNext == NEG_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
    end else if (tick) begin
      if (hitPos || hitNeg) preQ <= '0;
      else                  preQ <= preNext;
    end
  end

  assign stepOut.tick     = tick;
  assign stepOut.stepUp   = hitPos;
  assign stepOut.stepDown = hitNeg;

endmodule

// File: rtl/ampCodeReg.sv
module ampCodeReg
  import rat_pkg::*;
#(
  parameter int CODE_W    = 9,
  parameter int INIT_CODE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ampStep_t          stepIn,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(INIT_CODE);

  logic atMax;
  logic atMin;

  assign atMax = (code == CODE_MAX);
  assign atMin = (code == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code <= CODE_RST;
    end else if (stepIn.stepUp && !atMax) begin
      code <= code + 1'b1;
    end else if (stepIn.stepDown && !atMin) begin
      code <= code - 1'b1;
    end
  end

endmodule

// File: rtl/rippleAmpTracker.sv
module rippleAmpTracker
  import rat_pkg::*;
#(
  parameter int CODE_W      = 9,
  parameter int INIT_CODE   = 0,
  parameter int PRE_W       = 3,
  parameter int PRE_LIMIT   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swNode,
  input  logic              peakAboveValley,
  output logic [CODE_W-1:0] ampCode
);

  ampStep_t stepBus;

  ampTrackCtrl #(
    .PRE_W      (PRE_W),
    .PRE_LIMIT  (PRE_LIMIT),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .swNode (swNode),
    .ctrlIn (peakAboveValley),
    .stepOut(stepBus)
  );

  ampCodeReg #(
    .CODE_W   (CODE_W),
    .INIT_CODE(INIT_CODE)
  ) code_i (
    .clk   (clk),
    .rstN  (rstN),
    .stepIn(stepBus),
    .code  (ampCode)
  );

endmodule

// File: rtl/ampTrackChk.sv
module ampTrackChk
  import rat_pkg::*;
#(
  parameter int CODE_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input ampStep_t          stepS,
  input logic [CODE_W-1:0] ampCode
);

  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  p_single_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    stepS.tick |=> !stepS.tick);

  p_exclusive_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(stepS.stepUp && stepS.stepDown));

  p_up_direction_r3: assert property (@(posedge clk) disable iff (!rstN)
    stepS.stepUp |=> (ampCode >= $past(ampCode)));

  p_down_direction_r4: assert property (@(posedge clk) disable iff (!rstN)
    stepS.stepDown |=> (ampCode <= $past(ampCode)));

  p_no_wrap_top_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ampCode == TOP) |=> (ampCode != '0));

  p_no_wrap_bottom_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ampCode == '0) |=> (ampCode != TOP));

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stepS.tick |=> $stable(ampCode));

  p_unit_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((ampCode == $past(ampCode)) ||
              (ampCode == $past(ampCode) + 1'b1) ||
              (ampCode == $past(ampCode) - 1'b1)));

endmodule

bind rippleAmpTracker ampTrackChk #(.CODE_W(CODE_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .stepS  (stepBus),
  .ampCode(ampCode)
);

// File: tb/rippleAmpTracker_tb_top.sv
`timescale 1ns/1ps
module rippleAmpTracker_tb_top;

  localparam int CW    = 5;
  localparam int MAXC  = (1 << CW) - 1;
  localparam int LIM_A = 2;
  localparam int INI_A = 3;
  localparam int LIM_B = 3;
  localparam int INI_B = 28;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swNode = 1'b0;
  logic peakAboveValley = 1'b0;
  logic [CW-1:0] codeA;
  logic [CW-1:0] codeB;

  int checks = 0;
  int failures = 0;
  int preA = 0, expA = INI_A;
  int preB = 0, expB = INI_B;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rippleAmpTracker #(.CODE_W(CW), .INIT_CODE(INI_A), .PRE_LIMIT(LIM_A)) dut_i (
    .clk(clk), .rstN(rstN), .swNode(swNode),
    .peakAboveValley(peakAboveValley), .ampCode(codeA));

  rippleAmpTracker #(.CODE_W(CW), .INIT_CODE(INI_B), .PRE_LIMIT(LIM_B)) dutL3_i (
    .clk(clk), .rstN(rstN), .swNode(swNode),
    .peakAboveValley(peakAboveValley), .ampCode(codeB));

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep(inout int pre, inout int code, input int lim, input bit dec);
    if (dec) begin
      pre++;
      if (pre == lim) begin pre = 0; if (code < MAXC) code++; end
    end else begin
      pre--;
      if (pre == -lim) begin pre = 0; if (code > 0) code--; end
    end
  endtask

  task automatic checkBoth(input string tag);
    checkEq({tag, " lim2"}, int'(codeA), expA);
    checkEq({tag, " lim3"}, int'(codeB), expB);
  endtask

  // One switching period: decision held through the update clock, then noise.
  task automatic runCycle(input bit dec, input int highLen, input string tag);
    peakAboveValley = dec;
    swNode = 1'b1;
    waitClk(4);
    modelStep(preA, expA, LIM_A, dec);
    modelStep(preB, expB, LIM_B, dec);
    checkBoth(tag);
    repeat (highLen) begin peakAboveValley = ~peakAboveValley; waitClk(1); end
    swNode = 1'b0;
    repeat (4) begin peakAboveValley = ~peakAboveValley; waitClk(1); end
    checkBoth({tag, " R2 noise ignored"});
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    waitClk(3);
    checkBoth("R1 reset value");
    rstN = 1'b1;
    waitClk(2);
    checkBoth("R1 after release");

    // R1: centred pre-counter, one decision is not enough to step
    runCycle(1'b1, 3, "R1 first decision");
    runCycle(1'b1, 3, "R3 second decision");

    // R3 / R6: climb into the top clamp
    for (int i = 0; i < 60; i++) runCycle(1'b1, 2, "R6 upward run");
    checkEq("R6 clamp lim2", int'(codeA), MAXC);
    checkEq("R6 clamp lim3", int'(codeB), MAXC);

    // R5: alternating decisions hold the code
    for (int i = 0; i < 30; i++) runCycle(i[0], 2, "R5 alternating");
    checkEq("R5 hold lim2", int'(codeA), MAXC);

    // R4 / R7: descend into the bottom clamp
    for (int i = 0; i < 100; i++) runCycle(1'b0, 2, "R7 downward run");
    checkEq("R7 clamp lim2", int'(codeA), 0);
    checkEq("R7 clamp lim3", int'(codeB), 0);

    // R3 / R4: pseudo-random decisions
    lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      runCycle(lfsr[0] | lfsr[1], 1, "R3 R4 random mix");
    end

    // R2: long high levels still give one update each
    for (int i = 0; i < 12; i++) runCycle(1'b1, 37, "R2 long high");
    for (int i = 0; i < 12; i++) runCycle(1'b0, 41, "R2 long high down");

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule